// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an SPI host read and write a register space that sits behind a simple request/acknowledge port. Every transaction is a fixed 29-bit frame sent while the select line is held low. The frame carries a read/write bit, a 12-bit register address and an 8-bit data byte. When a frame of exactly the right length closes, the block turns it into one request on the register side. The backend answers with an acknowledge strobe, read data and a NACK indication.

The link is full duplex. While the host shifts a new frame in, the block shifts out a reply word built from the previous frame: its command and address, a status byte, and either the written byte or the byte that was read. Read data therefore reaches the host one frame later.

A frame that closes while the backend reports busy, or while an earlier request is still waiting for its acknowledge, is not issued. The reply then marks it as rejected. All SPI pins are sampled through a synchronizer into the single system clock domain. The only path that bypasses the synchronizer is the MISO output enable, which follows the select line directly.

Top module: `spi_regport`

## Requirements
- R1: While `spiSsN` is high, `spiMiso` is released (high impedance). It is driven as soon as `spiSsN` goes low, with no clock edge needed.
- R2: A frame is 29 bits, most significant bit first, with MOSI sampled on rising SCLK and MISO changing on falling SCLK (mode 0). Bit 28 selects the operation (1 = read, 0 = write), bits 27:16 hold the address and bits 7:0 hold the data.
- R3: A 29-bit frame that closes while the backend is idle and not busy raises `reqValid` once. `reqWrite`, `reqAddr` and `reqWdata` hold the frame's values and stay stable until the cycle `reqAck` is high, after which `reqValid` falls.
- R4: A frame with any bit count other than 29 issues no request and leaves the reply word unchanged.
- R5: SCLK and MOSI activity while `spiSsN` is high issues no request and does not alter the reply word.
- R6: Each frame shifts out the reply word held when that frame's select went low. After an acknowledged write, the reply word holds bit 28 = 0, the write address, and the written byte in bits 7:0.
- R7: After an acknowledged read, the reply word holds bit 28 = 1, the address, and `ackRdata` as sampled with `reqAck` in bits 7:0.
- R8: After an acknowledged request, reply bit 13 equals `beNack` as sampled with `reqAck`, and reply bits 15 and 12 are 0.
- R9: A 29-bit frame that closes while `beBusy` is high, or while a request is outstanding, issues no new request. The reply word becomes that frame's bit 28, address and data byte, with bit 15 (busy) and bit 12 (reject) set and bit 13 clear. An outstanding request that is acknowledged later overwrites the reply word as in R6 to R8.
- R10: Reply bits 14 and 11:8 are always 0, whatever the host sent in those positions.
- R11: After reset, `reqValid` is low and the reply word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | SPI serial clock from the host |
| spiSsN | input | 1 | SPI select, active low, frames a transaction |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial data to the host, released while select is high |
| reqValid | output | 1 | Register request pending |
| reqWrite | output | 1 | 1 for a write request, 0 for a read |
| reqAddr | output | 12 | Register address of the request |
| reqWdata | output | 8 | Write data of the request |
| reqAck | input | 1 | One-cycle acknowledge from the backend |
| ackRdata | input | 8 | Read data, valid with `reqAck` |
| beBusy | input | 1 | Backend cannot accept a request |
| beNack | input | 1 | Backend saw a NACK, valid with `reqAck` |

## Verification
The hardest case to reach is a complete frame arriving while an earlier request is still unacknowledged. Under normal traffic the backend answers long before the host can shift another 29 bits. To reach it, the bench's backend model holds its acknowledge behind a flag and sends a second full frame while the first request waits. It then checks that no second request appears and that the reply shows the reject form. Finally it releases the acknowledge and confirms that the late answer for the first request replaces the reply word.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 8;
  localparam int STAT_W  = 8;
  localparam int FRAME_W = 1 + ADDR_W + STAT_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int RW_POS  = FRAME_W - 1;

  // status byte bit positions (byte sits right above the data byte)
  localparam int ST_BUSY = 7;
  localparam int ST_NACK = 5;
  localparam int ST_REJ  = 4;

  typedef struct packed {
    logic latchCmd;   // capture received frame into the request registers
    logic echoAck;    // load reply word from the acknowledged request
    logic echoRej;    // load reply word in reject form from received frame
  } ctlStrobe_t;

  function automatic logic [FRAME_W-1:0] packFrame(
    input logic              rd,
    input logic [ADDR_W-1:0] addr,
    input logic              busy,
    input logic              nack,
    input logic              rej,
    input logic [DATA_W-1:0] data
  );
    logic [STAT_W-1:0] st;
    st          = '0;
    st[ST_BUSY] = busy;
    st[ST_NACK] = nack;
    st[ST_REJ]  = rej;
    return {rd, addr, st, data};
  endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RST_VAL;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/spi_regport_dp.sv
module spi_regport_dp
  import spi_regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              ssNIn,
  input  logic              mosiIn,
  input  ctlStrobe_t        stb,
  input  logic [DATA_W-1:0] ackRdata,
  input  logic              beNack,
  output logic              frameOk,
  output logic              misoBit,
  output logic              cmdRead,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdWdata
);

  localparam logic [2:0]       PIN_IDLE = 3'b010;   // {sclk, ssN, mosi}
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_W);
  localparam int BUSY_IDX = DATA_W + ST_BUSY;
  localparam int NACK_IDX = DATA_W + ST_NACK;
  localparam int REJ_IDX  = DATA_W + ST_REJ;

  logic [2:0] pinS;
  logic sclkS, ssNS, mosiS;
  logic sclkQ, ssNQ;
  logic sclkRise, sclkFall, ssFall, ssRise;
  logic shiftEn, outEn;

  logic [CNT_W-1:0]   bitCnt;
  logic [FRAME_W-1:0] rxShift;
  logic [FRAME_W-1:0] txShift;
  logic [FRAME_W-1:0] echo;

  logic              rxRead;
  logic [ADDR_W-1:0] rxAddr;
  logic [DATA_W-1:0] rxData;

  spi_regport_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({sclkIn, ssNIn, mosiIn}),
    .syncOut(pinS)
  );

  assign sclkS = pinS[2];
  assign ssNS  = pinS[1];
  assign mosiS = pinS[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      ssNQ  <= 1'b1;
    end else begin
      sclkQ <= sclkS;
      ssNQ  <= ssNS;
    end
  end

  assign sclkRise = sclkS & ~sclkQ;
  assign sclkFall = ~sclkS & sclkQ;
  assign ssFall   = ~ssNS & ssNQ;
  assign ssRise   = ssNS & ~ssNQ;
  assign shiftEn  = sclkRise & ~ssNS;
  assign outEn    = sclkFall & ~ssNS;

  // bit counter, saturates one past a good frame so long frames stay invalid
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             bitCnt <= '0;
    else if (ssFall)                       bitCnt <= '0;
    else if (shiftEn && bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rxShift <= '0;
    else if (shiftEn) rxShift <= {rxShift[FRAME_W-2:0], mosiS};
  end

  assign frameOk = ssRise && (bitCnt == CNT_GOOD);

  assign rxRead = rxShift[RW_POS];
  assign rxAddr = rxShift[RW_POS-1 -: ADDR_W];
  assign rxData = rxShift[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdRead  <= 1'b0;
      cmdAddr  <= '0;
      cmdWdata <= '0;
    end else if (stb.latchCmd) begin
      cmdRead  <= rxRead;
      cmdAddr  <= rxAddr;
      cmdWdata <= rxData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      echo <= '0;
    else if (stb.echoRej)
      echo <= packFrame(rxRead, rxAddr, 1'b1, 1'b0, 1'b1, rxData);
    else if (stb.echoAck)
      echo <= packFrame(cmdRead, cmdAddr, 1'b0, beNack, 1'b0,
                        cmdRead ? ackRdata : cmdWdata);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       txShift <= '0;
    else if (ssFall) txShift <= echo;
    else if (outEn)  txShift <= {txShift[FRAME_W-2:0], 1'b0};
  end

  assign misoBit = txShift[FRAME_W-1];

  // R4: the reply word moves only when control asks for it
  p_echo_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.echoAck || stb.echoRej) |=> $stable(echo));

  // R5: nothing is shifted in while select is released
  p_rx_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    ssNS |=> $stable(rxShift));

  // R9: a rejected frame leaves busy and reject set, NACK clear
  p_reject_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.echoRej |=> (echo[BUSY_IDX] && echo[REJ_IDX] && !echo[NACK_IDX]));

endmodule

// File: rtl/spi_regport_ctl.sv
module spi_regport_ctl
  import spi_regport_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameOk,
  input  logic       beBusy,
  input  logic       reqAck,
  output ctlStrobe_t stb,
  output logic       reqValid
);

  typedef enum logic {ST_IDLE, ST_WAIT} ctlState_t;

  ctlState_t state, stateNxt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (frameOk) begin
          if (beBusy) begin
            stb.echoRej = 1'b1;
          end else begin
            stb.latchCmd = 1'b1;
            stateNxt     = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (frameOk) begin
          stb.echoRej = 1'b1;
          if (reqAck) stateNxt = ST_IDLE;
        end else if (reqAck) begin
          stb.echoAck = 1'b1;
          stateNxt    = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign reqValid = (state == ST_WAIT);

  // R3: an acknowledge ends the request in the next cycle
  p_ack_drops_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAck) |=> !reqValid);

  // R9: a frame closing against a busy backend starts no request
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && frameOk && beBusy) |=> !reqValid);

endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiSsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic              reqValid,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWdata,
  input  logic              reqAck,
  input  logic [DATA_W-1:0] ackRdata,
  input  logic              beBusy,
  input  logic              beNack
);

  ctlStrobe_t stb;
  logic       frameOk;
  logic       misoBit;
  logic       cmdRead;

  spi_regport_dp #(
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .sclkIn  (spiSclk),
    .ssNIn   (spiSsN),
    .mosiIn  (spiMosi),
    .stb     (stb),
    .ackRdata(ackRdata),
    .beNack  (beNack),
    .frameOk (frameOk),
    .misoBit (misoBit),
    .cmdRead (cmdRead),
    .cmdAddr (reqAddr),
    .cmdWdata(reqWdata)
  );

  spi_regport_ctl ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .frameOk (frameOk),
    .beBusy  (beBusy),
    .reqAck  (reqAck),
    .stb     (stb),
    .reqValid(reqValid)
  );

  assign reqWrite = ~cmdRead;

  // output enable follows select directly, no clock involved
  assign spiMiso = spiSsN ? 1'bz : misoBit;

  // R3: request fields hold until acknowledged
  p_cmd_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqAck) |=> (reqValid && $stable({reqWrite, reqAddr, reqWdata})));

endmodule

// File: tb/spi_regport_tb_top.sv
module spi_regport_tb_top;

  localparam int HALF    = 8;      // clk cycles per SCLK half period
  localparam int ACK_DLY = 3;
  localparam int WD_CYC  = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        spiSclk = 1'b0;
  logic        spiSsN = 1'b1;
  logic        spiMosi = 1'b0;
  wire         spiMiso;
  logic        reqValid, reqWrite;
  logic [11:0] reqAddr;
  logic [7:0]  reqWdata;
  logic        reqAck = 1'b0;
  logic [7:0]  ackRdata = '0;
  logic        beBusy = 1'b0;
  logic        beNack = 1'b0;

  pullup (spiMiso);

  always #2 clk = ~clk;

  spi_regport dut_i (
    .clk(clk), .rstN(rstN),
    .spiSclk(spiSclk), .spiSsN(spiSsN), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqAck(reqAck), .ackRdata(ackRdata), .beBusy(beBusy), .beNack(beNack)
  );

  int nChecks = 0;
  int nErrs   = 0;

  logic [28:0] expQ[$];
  string       tagQ[$];
  logic [28:0] gotQ[$];
  logic [20:0] reqQ[$];
  event        frameDone;

  logic [28:0] modelEcho = '0;
  logic [28:0] savedAck  = '0;
  logic        pending   = 1'b0;
  logic        ackHold   = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [28:0] mk(input logic rd, input logic [11:0] a, input logic busy,
                                     input logic nack, input logic rej, input logic [7:0] d);
    return {rd, a, busy, 1'b0, nack, rej, 4'h0, d};
  endfunction

  function automatic logic [7:0] rdFn(input logic [11:0] a);
    return a[7:0] ^ 8'hA5 ^ {a[11:8], 4'h0};
  endfunction

  // echo scoreboard monitor
  initial begin
    forever begin
      @(frameDone);
      while (gotQ.size() > 0 && expQ.size() > 0) begin
        logic [28:0] g, e;
        string t;
        g = gotQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(g === e, t, "reply word", {3'b0, g}, {3'b0, e});
        check((g & 29'h0000_4F00) == 0, "R10", "reserved reply bits", {3'b0, g}, 32'h0);
      end
    end
  end

  // backend model and request scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (reqValid === 1'b1) begin
        repeat (ACK_DLY) @(negedge clk);
        while (ackHold) @(negedge clk);
        if (reqQ.size() == 0) begin
          check(1'b0, "R4", "unexpected request", {11'b0, reqWrite, reqAddr, reqWdata}, 32'h0);
        end else begin
          logic [20:0] r;
          r = reqQ.pop_front();
          check({reqWrite, reqAddr, reqWdata} === r, "R3", "request fields",
                {11'b0, reqWrite, reqAddr, reqWdata}, {11'b0, r});
        end
        ackRdata = rdFn(reqAddr);
        reqAck   = 1'b1;
        @(negedge clk);
        reqAck   = 1'b0;
        @(negedge clk);
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one SPI transaction; bits 14 and 11:8 sent as ones to show they are ignored
  task automatic doFrame(input logic rd, input logic [11:0] addr, input logic [7:0] data,
                         input int nBits, input string tag);
    logic [28:0] word, got;
    word = mk(rd, addr, 1'b0, 1'b0, 1'b0, data) | 29'h0000_4F00;
    got  = '0;
    if (nBits == 29) begin
      expQ.push_back(modelEcho);
      tagQ.push_back(tag);
    end
    @(negedge clk);
    spiSsN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < nBits; i++) begin
      spiMosi = (i < 29) ? word[28-i] : 1'b0;
      waitClk(HALF);
      got = {got[27:0], spiMiso};
      spiSclk = 1'b1;
      waitClk(HALF);
      spiSclk = 1'b0;
    end
    if (nBits == 29) begin
      if (beBusy || pending) begin
        modelEcho = mk(rd, addr, 1'b1, 1'b0, 1'b1, data);
      end else begin
        logic [28:0] ackForm;
        reqQ.push_back({~rd, addr, data});
        ackForm = mk(rd, addr, 1'b0, beNack, 1'b0, rd ? rdFn(addr) : data);
        if (ackHold) begin
          pending  = 1'b1;
          savedAck = ackForm;
        end else begin
          modelEcho = ackForm;
        end
      end
    end
    waitClk(HALF);
    spiSsN = 1'b1;
    if (nBits == 29) begin
      gotQ.push_back(got);
      -> frameDone;
    end
    waitClk(4 * HALF);
  endtask

  initial begin
    fork
      begin
        repeat (WD_CYC) @(posedge clk);
        nErrs++;
        nChecks++;
        $display("FAIL watchdog act=%0d exp=%0d", WD_CYC, 0);
        $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
        $finish;
      end
    join_none

    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R11 / R1: reset state
    check(reqValid === 1'b0, "R11", "reqValid after reset", {31'b0, reqValid}, 32'h0);
    check(spiMiso === 1'b1, "R1", "miso released after reset", {31'b0, spiMiso}, 32'h1);

    // R1: driven immediately on select low (reply word zero after reset)
    @(negedge clk);
    spiSsN = 1'b0;
    #0.5;
    check(spiMiso === 1'b0, "R1", "miso driven on select low", {31'b0, spiMiso}, 32'h0);
    @(negedge clk);
    spiSsN = 1'b1;
    #0.5;
    check(spiMiso === 1'b1, "R1", "miso released on select high", {31'b0, spiMiso}, 32'h1);
    waitClk(4 * HALF);

    // R11 / R6 / R2: write, then read shows write reply, then read reply
    doFrame(1'b0, 12'h123, 8'h3C, 29, "R11");
    doFrame(1'b1, 12'hABC, 8'h00, 29, "R6");
    doFrame(1'b0, 12'h5A0, 8'hC3, 29, "R7");
    doFrame(1'b1, 12'hFFF, 8'h11, 29, "R2");

    // R8: NACK reported by the backend
    beNack = 1'b1;
    doFrame(1'b0, 12'h00F, 8'h81, 29, "R7");
    beNack = 1'b0;
    doFrame(1'b1, 12'h800, 8'h00, 29, "R8");

    // R9: busy backend rejects the frame
    beBusy = 1'b1;
    doFrame(1'b0, 12'h2D4, 8'h77, 29, "R8");
    beBusy = 1'b0;
    doFrame(1'b1, 12'h010, 8'h00, 29, "R9");

    // R4: short and long frames are discarded
    doFrame(1'b0, 12'h333, 8'h44, 20, "R4");
    doFrame(1'b0, 12'h444, 8'h55, 31, "R4");
    doFrame(1'b0, 12'h555, 8'h66, 29, "R4");

    // R5: clocking with select high
    spiMosi = 1'b1;
    for (int k = 0; k < 30; k++) begin
      waitClk(HALF);
      spiSclk = 1'b1;
      check(spiMiso === 1'b1, "R5", "miso stays released", {31'b0, spiMiso}, 32'h1);
      waitClk(HALF);
      spiSclk = 1'b0;
    end
    spiMosi = 1'b0;
    waitClk(4 * HALF);
    check(reqValid === 1'b0, "R5", "no request from idle clocking", {31'b0, reqValid}, 32'h0);
    doFrame(1'b1, 12'h6E6, 8'h00, 29, "R5");

    // R9: frame while an earlier request is still outstanding
    ackHold = 1'b1;
    doFrame(1'b1, 12'h7A1, 8'h00, 29, "R7");
    check(reqValid === 1'b1, "R9", "request held outstanding", {31'b0, reqValid}, 32'h1);
    doFrame(1'b0, 12'h0B2, 8'h99, 29, "R9");
    check(reqValid === 1'b1, "R9", "still one outstanding request", {31'b0, reqValid}, 32'h1);
    ackHold = 1'b0;
    waitClk(4 * HALF);
    modelEcho = savedAck;
    pending   = 1'b0;
    check(reqValid === 1'b0, "R3", "request retired after ack", {31'b0, reqValid}, 32'h0);
    doFrame(1'b0, 12'h100, 8'h01, 29, "R9");
    doFrame(1'b0, 12'h200, 8'h02, 29, "R6");

    waitClk(10);
    check(reqQ.size() == 0, "R3", "all expected requests seen", reqQ.size(), 32'h0);
    check(expQ.size() == 0, "R6", "all replies compared", expQ.size(), 32'h0);

    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule